// File: doc/BRIEF.md
# Keyed Write-Protection Register Bank

This block holds a small bank of configuration registers behind a plain write port (address, data, strobe) and a combinational read port. A guard register carries an enable bit; while the enable bit is set, writes aimed at the registers marked as guarded are dropped. Each dropped write raises a sticky violation flag and records the address of the register it aimed at.

The guard register itself only takes a write whose upper field carries a fixed unlock key. A keyed write sets or clears the enable bit and also clears the violation flag. This makes one stray software store unable to switch the guard off or to hide the record of an earlier blocked access. Configuration contents have no meaning inside the block. They are storage that a neighbouring datapath consumes.

Top module: `wprot_regbank`

## Requirements
- R1: After a synchronous active-low reset, every configuration register, the guard enable, the violation flag and the source field read as zero.
- R2: With the guard off, a write to any configuration address 0..11 stores the data, and the data reads back at that address from the next cycle.
- R3: With the guard on, a write to a guarded address 0..9 leaves that register's content unchanged.
- R4: Any write that the guard blocks sets the violation flag, status bit 0 at address 13, from the next cycle on.
- R5: Status bits [11:8] hold the address of the most recent blocked write. A later violation overwrites the field, and a clear leaves it in place.
- R6: Addresses 10 and 11 are unguarded. Writes to them always store and never touch the violation flag.
- R7: A write to the guard register at address 12 is accepted only when bits [31:8] equal 24'hA5C0DE, and it then loads the enable bit from bit 0. A write with a wrong key changes nothing. While the guard is on, such a write also counts as a violation with source 12.
- R8: An accepted keyed write to address 12 clears the violation flag.
- R9: The status register at address 13 is read-only. Writes to it are ignored and are not violations, and reading it does not clear the flag.
- R10: Reading address 12 returns the enable bit in bit 0 and zero elsewhere. Addresses 14 and 15 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 4 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read word address |
| rd_data | output | 32 | Combinational read data |

## Verification
On every cycle, the assertions check five things. A guarded register holds its value across a blocked write. Unguarded registers take the written data. A blocked write raises the flag and loads the source field. A wrong-key guard write leaves the enable bit as it was. The flag falls only after a keyed write. Only the bench's scenarios show what software sees at the ports, using ordered sequences: the source field tracking the latest of several violations, a clear keeping the source, a wrong key ignored while the guard is off, reads of status leaving it intact, and reset in the middle of a run.

// File: rtl/wprot_pkg.sv
// Shared constants and types for the keyed write-protection register bank.
// Assumes word addressing and one write per cycle.
package wprot_pkg;
    localparam int                DATA_W    = 32;
    localparam int                ADDR_W    = 4;
    localparam int                NUM_CFG   = 12;
    localparam logic [NUM_CFG-1:0] GUARD_MAP = 12'h3FF;
    localparam int                GUARD_ADR = 12;
    localparam int                STAT_ADR  = 13;
    localparam int                KEY_W     = 24;
    localparam logic [KEY_W-1:0]  UNLOCK    = 24'hA5C0DE;
    localparam int                SRC_LSB   = 8;

    typedef enum logic [1:0] {
        CLS_CFG   = 2'd0,
        CLS_GUARD = 2'd1,
        CLS_STAT  = 2'd2,
        CLS_NONE  = 2'd3
    } addr_cls_e;
endpackage

// File: rtl/wprot_decode.sv
// Address decoder: turns a word address into a one-hot configuration
// select and an address class. Assumes the special addresses lie at or
// above NUM_CFG.
module wprot_decode
    import wprot_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int NCFG    = NUM_CFG,
    parameter int G_ADR   = GUARD_ADR,
    parameter int S_ADR   = STAT_ADR
) (
    input  logic [AW-1:0]   addr,
    output logic [NCFG-1:0] sel,
    output addr_cls_e       cls
);
    localparam int SPAN = 1 << AW;

    // One-hot select per configuration slot.
    generate
        for (genvar i = 0; i < NCFG; i++) begin : g_sel
            assign sel[i] = (int'(addr) == i);
        end
    endgenerate

    // Classify the address for the guard and the read mux.
    always_comb begin
        if (int'(addr) < NCFG)        cls = CLS_CFG;
        else if (int'(addr) == G_ADR) cls = CLS_GUARD;
        else if (int'(addr) == S_ADR) cls = CLS_STAT;
        else                          cls = CLS_NONE;
    end

    initial begin
        assert (NCFG <= SPAN && G_ADR >= NCFG && S_ADR >= NCFG && G_ADR != S_ADR)
            else $error("wprot_decode: address map overlaps");
    end
endmodule

// File: rtl/wprot_store.sv
// Configuration storage: NCFG registers of DW bits, each loaded when its
// write-enable bit is high. Assumes the write-enable bits already carry
// the protection decision.
module wprot_store
    import wprot_pkg::*;
#(
    parameter int DW   = DATA_W,
    parameter int NCFG = NUM_CFG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NCFG-1:0]    we_vec,
    input  logic [DW-1:0]      wdata,
    output logic [NCFG*DW-1:0] flat
);
    generate
        for (genvar i = 0; i < NCFG; i++) begin : g_reg
            // Hold or load one configuration word.
            always_ff @(posedge clk) begin
                if (!rst_n)        flat[i*DW +: DW] <= '0;
                else if (we_vec[i]) flat[i*DW +: DW] <= wdata;
            end
        end
    endgenerate
endmodule

// File: rtl/wprot_guard.sv
// Guard state: enable bit, sticky violation flag and source address.
// Assumes at most one write per cycle. The caller reports whether the
// target is a guarded slot or the guard register itself.
module wprot_guard
    import wprot_pkg::*;
#(
    parameter int              AW   = ADDR_W,
    parameter int              KW   = KEY_W,
    parameter logic [KW-1:0]   KEY  = UNLOCK
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [KW-1:0] key_in,
    input  logic          en_bit,
    input  logic          hit_guarded,
    input  logic          hit_guard_reg,
    output logic          guard_on,
    output logic          viol,
    output logic [AW-1:0] src
);
    logic key_ok;
    logic keyed_wr;
    logic bad_key_wr;
    logic blocked;

    // Qualify the write against the key and the current guard state.
    always_comb begin
        key_ok     = (key_in == KEY);
        keyed_wr   = wr_en && hit_guard_reg && key_ok;
        bad_key_wr = wr_en && hit_guard_reg && !key_ok;
        blocked    = guard_on && wr_en && (hit_guarded || bad_key_wr);
    end

    // Enable bit, loaded only by a keyed write.
    always_ff @(posedge clk) begin
        if (!rst_n)        guard_on <= 1'b0;
        else if (keyed_wr) guard_on <= en_bit;
    end

    // Sticky flag: a keyed write clears it, a blocked write sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)        viol <= 1'b0;
        else if (keyed_wr) viol <= 1'b0;
        else if (blocked)  viol <= 1'b1;
    end

    // Source field tracks the latest blocked target.
    always_ff @(posedge clk) begin
        if (!rst_n)       src <= '0;
        else if (blocked) src <= wr_addr;
    end

    // R4: a blocked write raises the flag
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> viol);
    // R5: the source field names the blocked target
    a_r5_src_latest: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> (src == $past(wr_addr)));
    // R7: a wrong key leaves the enable bit untouched
    a_r7_bad_key_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bad_key_wr |=> $stable(guard_on));
    // R8: a keyed write clears the flag
    a_r8_keyed_clear: assert property (@(posedge clk) disable iff (!rst_n)
        keyed_wr |=> !viol);
    // R8: the flag never falls without a keyed write
    a_r8_only_key_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(viol) |-> $past(keyed_wr));
endmodule

// File: rtl/wprot_regbank.sv
// Top of the keyed write-protection register bank. It combines decode,
// storage and guard, and drives a combinational read mux. Assumes a
// synchronous active-low reset and one write per cycle.
module wprot_regbank
    import wprot_pkg::*;
#(
    parameter int                DW        = DATA_W,
    parameter int                AW        = ADDR_W,
    parameter int                NCFG      = NUM_CFG,
    parameter logic [NCFG-1:0]   GUARDED   = GUARD_MAP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int KW = DW - SRC_LSB;

    logic [NCFG-1:0]    wsel, rsel, we_vec, allow;
    addr_cls_e          wcls, rcls;
    logic [NCFG*DW-1:0] flat;
    logic               guard_on, viol;
    logic [AW-1:0]      src;

    wprot_decode #(.AW(AW), .NCFG(NCFG), .G_ADR(GUARD_ADR), .S_ADR(STAT_ADR)) u_wdec (
        .addr(wr_addr), .sel(wsel), .cls(wcls)
    );

    wprot_decode #(.AW(AW), .NCFG(NCFG), .G_ADR(GUARD_ADR), .S_ADR(STAT_ADR)) u_rdec (
        .addr(rd_addr), .sel(rsel), .cls(rcls)
    );

    // Slots open for writing: all when off, only unguarded when on.
    always_comb begin
        allow  = guard_on ? ~GUARDED : {NCFG{1'b1}};
        we_vec = wsel & allow & {NCFG{wr_en && (wcls == CLS_CFG)}};
    end

    wprot_store #(.DW(DW), .NCFG(NCFG)) u_store (
        .clk(clk), .rst_n(rst_n), .we_vec(we_vec), .wdata(wr_data), .flat(flat)
    );

    wprot_guard #(.AW(AW), .KW(KW), .KEY(UNLOCK[KW-1:0])) u_guard (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .key_in(wr_data[DW-1 -: KW]), .en_bit(wr_data[0]),
        .hit_guarded((wcls == CLS_CFG) && |(wsel & GUARDED)),
        .hit_guard_reg(wcls == CLS_GUARD),
        .guard_on(guard_on), .viol(viol), .src(src)
    );

    // Read mux over storage, guard register and status.
    always_comb begin
        rd_data = '0;
        case (rcls)
            CLS_CFG: begin
                for (int i = 0; i < NCFG; i++)
                    if (rsel[i]) rd_data = flat[i*DW +: DW];
            end
            CLS_GUARD: rd_data[0] = guard_on;
            CLS_STAT: begin
                rd_data[0]               = viol;
                rd_data[SRC_LSB +: AW]   = src;
            end
            default: rd_data = '0;
        endcase
    end

    generate
        for (genvar i = 0; i < NCFG; i++) begin : g_chk
            if (GUARDED[i]) begin : g_prot
                // R3: a guarded slot holds across a write while the guard is on
                a_r3_guarded_hold: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_en && wsel[i] && guard_on) |=> $stable(flat[i*DW +: DW]));
            end else begin : g_open
                // R6: an unguarded slot always takes the written data
                a_r6_open_write: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_en && wsel[i]) |=> (flat[i*DW +: DW] == $past(wr_data)));
            end
        end
    endgenerate

    // R9: a write to status never moves the flag
    a_r9_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wcls == CLS_STAT) |=> $stable(viol));
endmodule

// File: tb/wprot_regbank_tb.sv
`timescale 1ns/1ps
// Bench for wprot_regbank: a vector table of write/read/expect steps,
// then directed reset and corner tests.
module wprot_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    localparam logic [23:0] KEY = 24'hA5C0DE;
    localparam int NV = 20;
    // {write?, waddr, wdata, raddr, expected read}
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 4'd0,  32'h1111_1111,     4'd0,  32'h1111_1111},  // R2
        {1'b1, 4'd9,  32'h0000_9999,     4'd9,  32'h0000_9999},  // R2
        {1'b1, 4'd12, {KEY, 8'h01},      4'd12, 32'h0000_0001},  // R7 enable
        {1'b1, 4'd0,  32'hDEAD_BEEF,     4'd0,  32'h1111_1111},  // R3
        {1'b0, 4'd0,  32'h0,             4'd13, 32'h0000_0001},  // R4 R5 src 0
        {1'b1, 4'd5,  32'h0000_1234,     4'd5,  32'h0000_0000},  // R3
        {1'b0, 4'd0,  32'h0,             4'd13, 32'h0000_0501},  // R5 latest
        {1'b1, 4'd10, 32'h0000_CAFE,     4'd10, 32'h0000_CAFE},  // R6
        {1'b0, 4'd0,  32'h0,             4'd13, 32'h0000_0501},  // R6 R9 no clear
        {1'b1, 4'd12, {24'h123456,8'h00},4'd12, 32'h0000_0001},  // R7 bad key
        {1'b0, 4'd0,  32'h0,             4'd13, 32'h0000_0C01},  // R7 src 12
        {1'b1, 4'd13, 32'hFFFF_FFFF,     4'd13, 32'h0000_0C01},  // R9
        {1'b1, 4'd12, {KEY, 8'h01},      4'd13, 32'h0000_0C00},  // R8 R5 keep src
        {1'b0, 4'd0,  32'h0,             4'd12, 32'h0000_0001},  // R10
        {1'b1, 4'd12, {KEY, 8'h00},      4'd12, 32'h0000_0000},  // R7 disable
        {1'b1, 4'd0,  32'h0000_0077,     4'd0,  32'h0000_0077},  // R2
        {1'b1, 4'd14, 32'h0000_ABCD,     4'd14, 32'h0000_0000},  // R10
        {1'b1, 4'd11, 32'h0000_0055,     4'd11, 32'h0000_0055},  // R6
        {1'b1, 4'd12, {24'h0BAD00,8'h01},4'd13, 32'h0000_0C00},  // R7 off no viol
        {1'b0, 4'd0,  32'h0,             4'd12, 32'h0000_0000}   // R7 still off
    };

    wprot_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic check(input logic [31:0] exp, input string tag);
        n_chk++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0d: got %h expected %h", tag, rd_addr, rd_data, exp);
        end
    endtask

    task automatic step(input logic we, input logic [3:0] wa, input logic [31:0] wd,
                        input logic [3:0] ra, input logic [31:0] exp, input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(negedge clk);
        wr_en = 1'b0; rd_addr = ra;
        #1 check(exp, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: everything reads zero after reset
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #1 check(32'h0, "R1");
        end
        for (int v = 0; v < NV; v++)
            step(VEC[v][72], VEC[v][71:68], VEC[v][67:36], VEC[v][35:32], VEC[v][31:0], "table");
        // R5: back-to-back violations, last one wins
        step(1'b1, 4'd12, {KEY, 8'h01}, 4'd12, 32'h1, "R7");
        step(1'b1, 4'd2, 32'h1, 4'd13, 32'h0000_0201, "R5");
        step(1'b1, 4'd7, 32'h1, 4'd13, 32'h0000_0701, "R5");
        step(1'b1, 4'd3, 32'h1, 4'd3, 32'h0, "R3");
        // R1: reset in the middle of a run clears all state
        do_reset();
        rd_addr = 4'd0;  #1 check(32'h0, "R1");
        rd_addr = 4'd10; #1 check(32'h0, "R1");
        rd_addr = 4'd12; #1 check(32'h0, "R1");
        rd_addr = 4'd13; #1 check(32'h0, "R1");
        // R2: guard off again after reset
        step(1'b1, 4'd3, 32'h0000_0033, 4'd3, 32'h0000_0033, "R2");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule